// File: doc/BRIEF.md
# Conditional Branch and Subroutine Sequencer

This block steers the program counter of a small 8-bit processor with a 16-bit address space. An external decoder hands it one control-flow command at a time, together with its operand bytes, the address of the next sequential instruction and the current sign, zero, parity and carry flags. The block can perform a jump, a jump to the address held in the HL register pair, a call, a return, or a restart to one of eight low-memory vectors. Jump, call and return can each be made conditional on a 3-bit condition code.

Calls and restarts push the return address onto a descending stack, one byte per cycle. Returns pop it back the same way. The block owns the program counter and the stack pointer, and it drives a byte-wide memory port with separate write and read strobes. Memory read data is taken in the same cycle as the address. A one-cycle `done` pulse marks the end of every command. `busy` is high while stack traffic is in progress, and a command offered during that time is not accepted.

Top module: `flow_branch_seq`

## Requirements
- R1: When `cmd_cond_en`=1, the condition code `cmd_cc` selects one flag and the level it must have for the command to be taken. Codes 0 and 1 test zero, 2 and 3 test carry, 4 and 5 test parity, 6 and 7 test sign. An even code requires the flag to be 0 and an odd code requires it to be 1. When `cmd_cond_en`=0 the command is always taken.
- R2: A taken jump (`cmd_op`=0) loads the PC with `{cmd_hi, cmd_lo}`. `done` and `taken`=1 appear in the cycle after acceptance, with no memory access. The PC changes only at the edge that raises `done`.
- R3: A taken call (`cmd_op`=1) writes `cmd_next_pc[15:8]` to SP-1 in the first cycle after acceptance, then writes `cmd_next_pc[7:0]` to SP-2 in the next cycle. `done` follows in the third cycle, with SP reduced by 2 and PC = `{cmd_hi, cmd_lo}`.
- R4: A taken return (`cmd_op`=2) reads the PC low byte at SP in the first cycle after acceptance and the high byte at SP+1 in the next cycle. `done` follows in the third cycle, with SP increased by 2.
- R5: A conditional jump, call or return whose condition fails loads the PC with `cmd_next_pc` and leaves SP unchanged. It makes no memory access and signals `done` with `taken`=0 in the cycle after acceptance.
- R6: A restart (`cmd_op`=3) is unconditional. It pushes `cmd_next_pc` exactly as a call does, then loads the PC with `cmd_vec` × 8, giving the vectors 0x0000 to 0x0038.
- R7: Jump-through-HL (`cmd_op`=4) is unconditional. It loads the PC with `cmd_hl` in the cycle after acceptance, with no memory access.
- R8: `busy` is high during every stack-access cycle. A command offered while `busy` is high is ignored, and only one `done` pulse is produced per accepted command.
- R9: After reset, PC = `PC_RESET`, SP = `SP_RESET`, and `busy`, `done`, `mem_we` and `mem_re` are all 0.
- R10: Stack addresses and SP arithmetic wrap modulo 2^16. For example, a push from SP = 0x0000 writes 0xFFFF and then 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered; accepted when `busy` is low |
| cmd_op | input | 3 | 0 jump, 1 call, 2 return, 3 restart, 4 jump via HL |
| cmd_cond_en | input | 1 | Make the jump, call or return conditional |
| cmd_cc | input | 3 | Condition code |
| cmd_vec | input | 3 | Restart vector number |
| cmd_lo | input | 8 | Target address low byte |
| cmd_hi | input | 8 | Target address high byte |
| cmd_hl | input | 16 | HL pair value |
| cmd_next_pc | input | 16 | Address of the following instruction |
| flag_sign | input | 1 | Sign flag |
| flag_zero | input | 1 | Zero flag |
| flag_parity | input | 1 | Parity flag |
| flag_carry | input | 1 | Carry flag |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack write byte |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read byte, valid in the same cycle as `mem_addr` |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Stack sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Last completed command changed flow |

## Verification
The bench tries every condition code against all sixteen flag combinations. A wrong flag selection or an inverted polarity would show up as a PC landing on the target when it should take the fall-through address, or the other way round. It pushes the stack across address zero. An SP computed at the wrong width, or bytes stored in swapped order, would then return a corrupted address. It offers a new jump while a call is still pushing. A design that accepted it would overwrite the call target or pulse `done` twice. It also sweeps all eight restart vectors, so a wrong shift would send control to the wrong handler.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int CC_W = 3;

  typedef enum logic [2:0] {
    OP_JMP  = 3'd0,
    OP_CALL = 3'd1,
    OP_RET  = 3'd2,
    OP_RST  = 3'd3,
    OP_JHL  = 3'd4
  } flow_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_HI = 3'd1,
    ST_PUSH_LO = 3'd2,
    ST_POP_LO  = 3'd3,
    ST_POP_HI  = 3'd4
  } seq_state_e;

  // Reference formulation of the condition table, by case on the code.
  function automatic logic cc_reference(input logic [CC_W-1:0] cc,
                                        input logic s, input logic z,
                                        input logic p, input logic c);
    case (cc)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !c;
      3'd3: return c;
      3'd4: return !p;
      3'd5: return p;
      3'd6: return !s;
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
  import flow_pkg::*;
(
  input  logic            cond_en,
  input  logic [CC_W-1:0] cc,
  input  logic            f_sign,
  input  logic            f_zero,
  input  logic            f_parity,
  input  logic            f_carry,
  output logic            met
);
  localparam int NCODES = 1 << CC_W;

  // Flag selected by the upper code bits: zero, carry, parity, sign.
  logic [3:0]        flag_vec;
  logic [NCODES-1:0] code_hit;

  assign flag_vec = {f_sign, f_parity, f_carry, f_zero};

  for (genvar i = 0; i < NCODES; i++) begin : g_code
    localparam logic [CC_W-1:0] CODE = CC_W'(i);
    assign code_hit[i] = (cc == CODE) && (flag_vec[CODE[CC_W-1:1]] == CODE[0]);
  end

  assign met = !cond_en || (|code_hit);

  always_comb begin
    a_r1_single_code: assert ($onehot0(code_hit));
    a_r1_table_match: assert (!cond_en -> met)
      else $error("unconditional command reported as not met");
    a_r1_ref_match: assert (!cond_en || (met == cc_reference(cc, f_sign, f_zero, f_parity, f_carry)));
  end
endmodule

// File: rtl/flow_stack_seq.sv
module flow_stack_seq
  import flow_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int VEC_W     = 3,
  parameter int VEC_SHIFT = 3,
  parameter logic [2*DATA_W-1:0] SP_RESET = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic                met,
  input  logic [2*DATA_W-1:0] next_pc,
  input  logic [2*DATA_W-1:0] target,
  input  logic [2*DATA_W-1:0] hl,
  input  logic [VEC_W-1:0]    vec,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  output logic [2*DATA_W-1:0] sp,
  output logic                busy,
  output logic                pc_load,
  output logic [2*DATA_W-1:0] pc_val,
  output logic                done,
  output logic                taken
);
  localparam int ADDR_W = 2 * DATA_W;

  function automatic logic [ADDR_W-1:0] sp_step(input logic [ADDR_W-1:0] base,
                                                input logic down,
                                                input logic [1:0] amount);
    return down ? base - ADDR_W'(amount) : base + ADDR_W'(amount);
  endfunction

  function automatic logic [ADDR_W-1:0] vec_addr(input logic [VEC_W-1:0] v);
    return ADDR_W'(v) << VEC_SHIFT;
  endfunction

  seq_state_e        state_q, state_d;
  flow_op_e          op_e;
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic [ADDR_W-1:0] ret_q, ret_d;
  logic [ADDR_W-1:0] dest_q, dest_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  logic              done_q, done_d;
  logic              taken_q, taken_d;

  // Named events for the assertions.
  logic push_hi_ev, push_end_ev, pop_lo_ev, pop_end_ev, quick_ev;

  assign op_e        = flow_op_e'(op);
  assign push_hi_ev  = (state_q == ST_PUSH_HI);
  assign push_end_ev = (state_q == ST_PUSH_LO);
  assign pop_lo_ev   = (state_q == ST_POP_LO);
  assign pop_end_ev  = (state_q == ST_POP_HI);
  assign quick_ev    = (state_q == ST_IDLE) && start && (state_d == ST_IDLE);

  always_comb begin
    state_d = state_q;
    sp_d    = sp_q;
    ret_d   = ret_q;
    dest_d  = dest_q;
    lo_d    = lo_q;
    done_d  = 1'b0;
    taken_d = taken_q;
    pc_load = 1'b0;
    pc_val  = next_pc;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          case (op_e)
            OP_JMP: begin
              pc_load = 1'b1;
              pc_val  = met ? target : next_pc;
              done_d  = 1'b1;
              taken_d = met;
            end
            OP_JHL: begin
              pc_load = 1'b1;
              pc_val  = hl;
              done_d  = 1'b1;
              taken_d = 1'b1;
            end
            OP_CALL, OP_RST: begin
              if (met || op_e == OP_RST) begin
                state_d = ST_PUSH_HI;
                ret_d   = next_pc;
                dest_d  = (op_e == OP_RST) ? vec_addr(vec) : target;
              end else begin
                pc_load = 1'b1;
                done_d  = 1'b1;
                taken_d = 1'b0;
              end
            end
            OP_RET: begin
              if (met) begin
                state_d = ST_POP_LO;
              end else begin
                pc_load = 1'b1;
                done_d  = 1'b1;
                taken_d = 1'b0;
              end
            end
            default: begin
              pc_load = 1'b1;
              done_d  = 1'b1;
              taken_d = 1'b0;
            end
          endcase
        end
      end
      ST_PUSH_HI: state_d = ST_PUSH_LO;
      ST_PUSH_LO: begin
        state_d = ST_IDLE;
        sp_d    = sp_step(sp_q, 1'b1, 2'd2);
        pc_load = 1'b1;
        pc_val  = dest_q;
        done_d  = 1'b1;
        taken_d = 1'b1;
      end
      ST_POP_LO: begin
        state_d = ST_POP_HI;
        lo_d    = mem_rdata;
      end
      ST_POP_HI: begin
        state_d = ST_IDLE;
        sp_d    = sp_step(sp_q, 1'b0, 2'd2);
        pc_load = 1'b1;
        pc_val  = {mem_rdata, lo_q};
        done_d  = 1'b1;
        taken_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp_q;
    mem_wdata = '0;
    unique case (state_q)
      ST_PUSH_HI: begin
        mem_we    = 1'b1;
        mem_addr  = sp_step(sp_q, 1'b1, 2'd1);
        mem_wdata = ret_q[ADDR_W-1:DATA_W];
      end
      ST_PUSH_LO: begin
        mem_we    = 1'b1;
        mem_addr  = sp_step(sp_q, 1'b1, 2'd2);
        mem_wdata = ret_q[DATA_W-1:0];
      end
      ST_POP_LO: begin
        mem_re   = 1'b1;
        mem_addr = sp_q;
      end
      ST_POP_HI: begin
        mem_re   = 1'b1;
        mem_addr = sp_step(sp_q, 1'b0, 2'd1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= SP_RESET;
      ret_q   <= '0;
      dest_q  <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      ret_q   <= ret_d;
      dest_q  <= dest_d;
      lo_q    <= lo_d;
      done_q  <= done_d;
      taken_q <= taken_d;
    end
  end

  assign sp    = sp_q;
  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;
  assign taken = taken_q;

  a_r3_push_order: assert property (@(posedge clk) disable iff (!rst_n)
    push_hi_ev |=> mem_we && (mem_addr == $past(mem_addr) - ADDR_W'(1)));
  a_r3_sp_down: assert property (@(posedge clk) disable iff (!rst_n)
    push_end_ev |=> (sp == $past(sp) - ADDR_W'(2)) && done);
  a_r4_pop_order: assert property (@(posedge clk) disable iff (!rst_n)
    pop_lo_ev |=> mem_re && (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  a_r4_sp_up: assert property (@(posedge clk) disable iff (!rst_n)
    pop_end_ev |=> (sp == $past(sp) + ADDR_W'(2)) && done);
  a_r5_quick_finish: assert property (@(posedge clk) disable iff (!rst_n)
    quick_ev |=> done && !busy && $stable(sp));
  a_r8_sp_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> done);
  a_r8_strobes_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy && !(mem_we && mem_re));
endmodule

// File: rtl/flow_branch_seq.sv
module flow_branch_seq
  import flow_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int VEC_W     = 3,
  parameter int VEC_SHIFT = 3,
  parameter logic [2*DATA_W-1:0] SP_RESET = '0,
  parameter logic [2*DATA_W-1:0] PC_RESET = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic                cmd_cond_en,
  input  logic [CC_W-1:0]     cmd_cc,
  input  logic [VEC_W-1:0]    cmd_vec,
  input  logic [DATA_W-1:0]   cmd_lo,
  input  logic [DATA_W-1:0]   cmd_hi,
  input  logic [2*DATA_W-1:0] cmd_hl,
  input  logic [2*DATA_W-1:0] cmd_next_pc,
  input  logic                flag_sign,
  input  logic                flag_zero,
  input  logic                flag_parity,
  input  logic                flag_carry,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [2*DATA_W-1:0] pc,
  output logic [2*DATA_W-1:0] sp,
  output logic                busy,
  output logic                done,
  output logic                taken
);
  localparam int ADDR_W = 2 * DATA_W;

  logic              start;
  logic              cond_met;
  logic              pc_load;
  logic [ADDR_W-1:0] pc_val;
  logic [ADDR_W-1:0] pc_q;

  assign start = cmd_valid && !busy;

  flow_cond_eval u_cond (
    .cond_en  (cmd_cond_en),
    .cc       (cmd_cc),
    .f_sign   (flag_sign),
    .f_zero   (flag_zero),
    .f_parity (flag_parity),
    .f_carry  (flag_carry),
    .met      (cond_met)
  );

  flow_stack_seq #(
    .DATA_W    (DATA_W),
    .VEC_W     (VEC_W),
    .VEC_SHIFT (VEC_SHIFT),
    .SP_RESET  (SP_RESET)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (cmd_op),
    .met       (cond_met),
    .next_pc   (cmd_next_pc),
    .target    ({cmd_hi, cmd_lo}),
    .hl        (cmd_hl),
    .vec       (cmd_vec),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .sp        (sp),
    .busy      (busy),
    .pc_load   (pc_load),
    .pc_val    (pc_val),
    .done      (done),
    .taken     (taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= PC_RESET;
    else if (pc_load) pc_q <= pc_val;
  end

  assign pc = pc_q;

  a_r2_pc_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> done);
  a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !$past(done));
  a_r7_hl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cmd_op == 3'd4) |=> done && (pc == $past(cmd_hl)));
endmodule

// File: tb/test_flow_branch_seq.sv
module test_flow_branch_seq;
  localparam logic [15:0] SP0 = 16'h0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        cmd_cond_en = 1'b0;
  logic [2:0]  cmd_cc = '0;
  logic [2:0]  cmd_vec = '0;
  logic [7:0]  cmd_lo = '0, cmd_hi = '0;
  logic [15:0] cmd_hl = '0, cmd_next_pc = '0;
  logic        flag_sign = 0, flag_zero = 0, flag_parity = 0, flag_carry = 0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, mem_re;
  logic [15:0] pc, sp;
  logic        busy, done, taken;

  logic [7:0]  mem [256];
  int          checks = 0, errors = 0, acc_cnt = 0, wr_n = 0;
  logic [15:0] wr_addr [4];
  logic [7:0]  wr_data [4];
  int          cycles;

  always #2.5 clk = ~clk;

  flow_branch_seq #(.SP_RESET(SP0)) i_flow_branch_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_cond_en(cmd_cond_en), .cmd_cc(cmd_cc), .cmd_vec(cmd_vec),
    .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .cmd_hl(cmd_hl), .cmd_next_pc(cmd_next_pc),
    .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_parity(flag_parity),
    .flag_carry(flag_carry), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .pc(pc), .sp(sp),
    .busy(busy), .done(done), .taken(taken));

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we || mem_re) acc_cnt++;
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      if (wr_n < 4) begin
        wr_addr[wr_n] = mem_addr;
        wr_data[wr_n] = mem_wdata;
      end
      wr_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exp_taken(input logic [2:0] cc, input logic [3:0] f);
    // f = {sign, zero, parity, carry}
    logic sel;
    case (cc >> 1)
      3'd0: sel = f[2];
      3'd1: sel = f[0];
      3'd2: sel = f[1];
      default: sel = f[3];
    endcase
    return sel == cc[0];
  endfunction

  // Issue one command; with poke set, keep offering a jump while busy.
  task automatic issue(input logic [2:0] op, input logic cen, input logic [2:0] cc,
                       input logic [3:0] f, input logic [15:0] tgt, input logic [15:0] hl,
                       input logic [2:0] vec, input logic [15:0] npc, input bit poke);
    @(negedge clk);
    cmd_op = op; cmd_cond_en = cen; cmd_cc = cc;
    {flag_sign, flag_zero, flag_parity, flag_carry} = f;
    cmd_lo = tgt[7:0]; cmd_hi = tgt[15:8]; cmd_hl = hl; cmd_vec = vec;
    cmd_next_pc = npc; cmd_valid = 1'b1;
    wr_n = 0; acc_cnt = 0;
    @(negedge clk);
    cycles = 1;
    if (poke) begin
      check(busy === 1'b1, "R8 busy during push", 32'(busy), 32'd1);
      cmd_op = 3'd0; cmd_cond_en = 1'b0; cmd_lo = 8'h77; cmd_hi = 8'h77;
    end else cmd_valid = 1'b0;
    while (!done && cycles < 20) begin
      @(negedge clk);
      cycles++;
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(pc === 16'h0000, "R9 pc reset", 32'(pc), 32'h0);
    check(sp === SP0, "R9 sp reset", 32'(sp), 32'(SP0));
    check({busy, done, mem_we, mem_re} === 4'b0, "R9 idle outputs",
          32'({busy, done, mem_we, mem_re}), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R2/R5: every code against every flag combination (codes: 0/1 zero, 2/3 carry, 4/5 parity, 6/7 sign; odd = flag set)
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 16; f++) begin
        logic [15:0] tgt, npc;
        bit t;
        tgt = 16'h8000 | 16'(cc * 16 + f);
        npc = 16'h4000 | 16'(cc * 16 + f);
        t = exp_taken(3'(cc), 4'(f));
        issue(3'd0, 1'b1, 3'(cc), 4'(f), tgt, 16'h0, 3'd0, npc, 1'b0);
        check(pc === (t ? tgt : npc), "R1 conditional jump pc", 32'(pc), 32'(t ? tgt : npc));
        check(taken === t && cycles == 1 && acc_cnt == 0, "R5 R2 one cycle no access",
              32'({taken, 8'(cycles), 8'(acc_cnt)}), 32'({t, 8'd1, 8'd0}));
      end
    end

    // R2 unconditional jump ignores failing flags
    issue(3'd0, 1'b0, 3'd1, 4'b0000, 16'h1357, 16'h0, 3'd0, 16'h0042, 1'b0);
    check(pc === 16'h1357 && taken === 1'b1, "R2 unconditional jump", 32'(pc), 32'h1357);

    // R7 jump via HL
    issue(3'd4, 1'b1, 3'd1, 4'b0000, 16'h1111, 16'hBEEF, 3'd0, 16'h2222, 1'b0);
    check(pc === 16'hBEEF && cycles == 1 && acc_cnt == 0, "R7 jump via hl", 32'(pc), 32'hBEEF);

    // R3 call from SP=0x0003
    issue(3'd1, 1'b0, 3'd0, 4'b0, 16'h4000, 16'h0, 3'd0, 16'h1234, 1'b0);
    check(cycles == 3, "R3 call latency", 32'(cycles), 32'd3);
    check(wr_addr[0] === 16'h0002 && wr_data[0] === 8'h12, "R3 first write high byte",
          32'({wr_addr[0], wr_data[0]}), 32'h000212);
    check(wr_addr[1] === 16'h0001 && wr_data[1] === 8'h34, "R3 second write low byte",
          32'({wr_addr[1], wr_data[1]}), 32'h000134);
    check(sp === 16'h0001 && pc === 16'h4000, "R3 call sp and pc",
          32'({sp, pc}), 32'h00014000);

    // R8 + R10: conditional call taken (zero set, code 1) while a jump is offered during busy; wraps below zero
    issue(3'd1, 1'b1, 3'd1, 4'b0100, 16'h5000, 16'h0, 3'd0, 16'hA55A, 1'b1);
    check(pc === 16'h5000, "R8 jump offered while busy ignored", 32'(pc), 32'h5000);
    @(negedge clk);
    check(done === 1'b0 && pc === 16'h5000, "R8 single done pulse", 32'({done, pc}), 32'h05000);
    check(wr_addr[0] === 16'h0000 && wr_addr[1] === 16'hFFFF, "R10 push wraps",
          32'({wr_addr[0], wr_addr[1]}), 32'h0000FFFF);
    check(sp === 16'hFFFF, "R10 sp wraps", 32'(sp), 32'hFFFF);

    // R5 conditional call not taken (code 1 with zero clear)
    issue(3'd1, 1'b1, 3'd1, 4'b0000, 16'h6000, 16'h0, 3'd0, 16'h0099, 1'b0);
    check(pc === 16'h0099 && sp === 16'hFFFF && acc_cnt == 0 && taken === 1'b0,
          "R5 call not taken", 32'({pc, sp}), 32'h0099FFFF);

    // R5 conditional return not taken (code 3 with carry clear)
    issue(3'd2, 1'b1, 3'd3, 4'b0000, 16'h0, 16'h0, 3'd0, 16'h00AB, 1'b0);
    check(pc === 16'h00AB && sp === 16'hFFFF && acc_cnt == 0, "R5 return not taken",
          32'({pc, sp}), 32'h00ABFFFF);

    // R4 + R10 conditional return taken (code 0 with zero clear), pops across zero
    issue(3'd2, 1'b1, 3'd0, 4'b0000, 16'h0, 16'h0, 3'd0, 16'h0077, 1'b0);
    check(cycles == 3 && pc === 16'hA55A, "R4 return pc", 32'(pc), 32'hA55A);
    check(sp === 16'h0001, "R4 R10 return sp", 32'(sp), 32'h0001);

    // R6 restart sweep: vector*8, then return restores
    for (int v = 0; v < 8; v++) begin
      logic [15:0] npc;
      npc = 16'h3000 + 16'(v * 257);
      issue(3'd3, 1'b1, 3'd1, 4'b0000, 16'hFFFF, 16'h0, 3'(v), npc, 1'b0);
      check(pc === 16'(v * 8) && sp === 16'hFFFF && cycles == 3, "R6 restart vector",
            32'({pc, sp}), 32'({16'(v * 8), 16'hFFFF}));
      issue(3'd2, 1'b0, 3'd0, 4'b0, 16'h0, 16'h0, 3'd0, 16'h0, 1'b0);
      check(pc === npc && sp === 16'h0001, "R6 R4 restart return", 32'({pc, sp}),
            32'({npc, 16'h0001}));
    end

    // R4 final unconditional return to the first caller
    issue(3'd2, 1'b0, 3'd0, 4'b0, 16'h0, 16'h0, 3'd0, 16'h0, 1'b0);
    check(pc === 16'h1234 && sp === SP0, "R4 unconditional return", 32'({pc, sp}),
          32'({16'h1234, SP0}));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule